// File: doc/BRIEF.md
# Twisted-Pair SQE Test Generator

This block produces the simulated collision pulse that a twisted-pair transceiver sends back to its MAC after every transmission. The pulse lets the MAC confirm that its collision-sensing path works without anything being sent on the line. The block runs on the bit-rate clock. It watches the transmit enable from the MAC. When a frame ends, it counts a fixed delay, then holds the collision output high for a fixed number of bit times.

Whether a pulse is produced depends on the port and test-mode flags as they stand at the end of the frame:

- The twisted-pair port must be selected.
- The active-low test enable must be low.
- Full-duplex operation suppresses the pulse, unless diagnostic loopback is also on.
- With the attachment-unit port selected, the block stays silent, because the external transceiver supplies that signal.

Any transmit activity cancels a pending or running pulse. Each new frame therefore gets its own pulse, timed from its own end.

Top module: `sqe_test_gen`

## Requirements
- R1: While `rst` is high on a clock edge, `col_o` is low after that edge, and no pulse owed from before the reset appears later.
- R2: When a qualifying frame ends, `col_o` rises exactly `DELAY` clock edges after the end. The end is the first edge at which `tx_en` is sampled 0 after being sampled 1. `DELAY` defaults to 10 and must lie in 6 to 16; a value outside that window stops elaboration.
- R3: An uninterrupted pulse holds `col_o` high for exactly `WIDTH` cycles. `WIDTH` defaults to 10 and must lie in 5 to 15; a value outside that window stops elaboration.
- R4: A pulse is produced only if `tp_sel` = 1 (twisted-pair port; 0 means the attachment-unit port) and `sqe_test_n` = 0 at the end of the frame. Otherwise `col_o` stays low.
- R5: With `full_dup` = 1 and `loopback` = 0 at the end of the frame, no pulse is produced.
- R6: With `loopback` = 1, a pulse still follows each frame under the conditions of R4, even when `full_dup` = 1.
- R7: On the edge after any edge at which `tx_en` is sampled 1, `col_o` is low. A new frame therefore cancels a pending or running pulse.
- R8: For back-to-back frames, each qualifying frame end starts a fresh full pulse timed from that end, even if an earlier pulse was cancelled.
- R9: The mode flags count only at the end of the frame. Changing them during the delay or the pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC; its falling edge marks the end of a frame |
| tp_sel | input | 1 | 1 selects the twisted-pair port, 0 the attachment-unit port |
| sqe_test_n | input | 1 | Active-low SQE test enable |
| full_dup | input | 1 | Full-duplex operation flag |
| loopback | input | 1 | Diagnostic loopback flag |
| col_o | output | 1 | Collision indication to the MAC |

## Verification
The checker watches every cycle for the following properties:

- the rise of the collision output falls exactly the programmed delay after the last frame end;
- a rise happens only if the mode flags qualified that frame end;
- no pulse runs longer than the programmed width, and a pulse that is not cancelled lasts exactly that width;
- the output is low after any cycle with transmit enable high or with reset high.

Other behaviour needs the bench's scenarios to show it:

- each mode combination actually yields its pulse or silence, since a missing pulse trips no property;
- a pulse cancelled by a back-to-back frame is replaced by a full one;
- mode changes after a frame end leave that pulse alone;
- reset in the middle of a pulse leaves nothing owed.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

    localparam int unsigned DLY_MIN = 6;
    localparam int unsigned DLY_MAX = 16;
    localparam int unsigned WID_MIN = 5;
    localparam int unsigned WID_MAX = 15;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } sqe_state_e;

    typedef struct packed {
        logic tp_sel;
        logic sqe_en;
        logic fdx;
        logic lpbk;
    } sqe_mode_s;

    // Pulse permitted on twisted pair with test enabled; full duplex blocks
    // it unless loopback isolates the line.
    function automatic logic mode_allows(sqe_mode_s m);
        return m.tp_sel & m.sqe_en & (~m.fdx | m.lpbk);
    endfunction

    function automatic int unsigned cnt_bits(int unsigned a, int unsigned b);
        int unsigned mx;
        mx = (a > b) ? a : b;
        return (mx < 2) ? 1 : $clog2(mx + 1);
    endfunction

endpackage

// File: rtl/sqe_eof_detect.sv
module sqe_eof_detect (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    output logic eof_o,
    output logic abort_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= tx_en;
    end

    assign eof_o   = en_q & ~tx_en;
    assign abort_o = tx_en;
endmodule

// File: rtl/sqe_mode_qual.sv
module sqe_mode_qual
    import sqe_pkg::*;
(
    input  logic tp_sel,
    input  logic sqe_test_n,
    input  logic full_dup,
    input  logic loopback,
    input  logic eof,
    output logic start_o
);
    sqe_mode_s mode;

    always_comb begin
        mode.tp_sel = tp_sel;
        mode.sqe_en = ~sqe_test_n;
        mode.fdx    = full_dup;
        mode.lpbk   = loopback;
    end

    assign start_o = eof & mode_allows(mode);
endmodule

// File: rtl/sqe_pulse_timer.sv
module sqe_pulse_timer
    import sqe_pkg::*;
#(
    parameter int unsigned DELAY = 10,
    parameter int unsigned WIDTH = 10,
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic pulse_o
);
    typedef struct packed {
        sqe_state_e       state;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'(DELAY - 1);
    localparam logic [CNT_W-1:0] WID_LOAD = CNT_W'(WIDTH - 1);

    tmr_s cur, nxt;

    always_comb begin
        nxt = cur;
        if (abort) begin
            nxt.state = ST_IDLE;
            nxt.cnt   = '0;
        end else begin
            unique case (cur.state)
                ST_IDLE: begin
                    if (start) begin
                        nxt.state = ST_WAIT;
                        nxt.cnt   = DLY_LOAD;
                    end
                end
                ST_WAIT: begin
                    if (cur.cnt == '0) begin
                        nxt.state = ST_PULSE;
                        nxt.cnt   = WID_LOAD;
                    end else begin
                        nxt.cnt = cur.cnt - 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (cur.cnt == '0) begin
                        nxt.state = ST_IDLE;
                    end else begin
                        nxt.cnt = cur.cnt - 1'b1;
                    end
                end
                default: begin
                    nxt.state = ST_IDLE;
                    nxt.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.state <= ST_IDLE;
            cur.cnt   <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign pulse_o = (cur.state == ST_PULSE);
endmodule

// File: rtl/sqe_test_gen.sv
module sqe_test_gen
    import sqe_pkg::*;
#(
    parameter int unsigned DELAY = 10,
    parameter int unsigned WIDTH = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tp_sel,
    input  logic sqe_test_n,
    input  logic full_dup,
    input  logic loopback,
    output logic col_o
);
    localparam int unsigned CNT_W = cnt_bits(DELAY, WIDTH);

    // R2 / R3: timing windows enforced at elaboration.
    if (DELAY < DLY_MIN || DELAY > DLY_MAX) begin : g_bad_delay
        $error("sqe_test_gen: DELAY %0d outside %0d..%0d", DELAY, DLY_MIN, DLY_MAX);
    end
    if (WIDTH < WID_MIN || WIDTH > WID_MAX) begin : g_bad_width
        $error("sqe_test_gen: WIDTH %0d outside %0d..%0d", WIDTH, WID_MIN, WID_MAX);
    end

    logic eof, abort, start;

    sqe_eof_detect u_eof (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .eof_o   (eof),
        .abort_o (abort)
    );

    sqe_mode_qual u_qual (
        .tp_sel     (tp_sel),
        .sqe_test_n (sqe_test_n),
        .full_dup   (full_dup),
        .loopback   (loopback),
        .eof        (eof),
        .start_o    (start)
    );

    sqe_pulse_timer #(
        .DELAY (DELAY),
        .WIDTH (WIDTH),
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (abort),
        .pulse_o (col_o)
    );
endmodule

// File: rtl/sqe_test_gen_chk.sv
module sqe_test_gen_chk #(
    parameter int unsigned DELAY = 10,
    parameter int unsigned WIDTH = 10
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tp_sel,
    input logic sqe_test_n,
    input logic full_dup,
    input logic loopback,
    input logic col_o
);
    logic       en_seen;
    logic [7:0] since_end;
    logic       end_ok;
    logic [7:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_seen   <= 1'b0;
            since_end <= 8'hFF;
            end_ok    <= 1'b0;
            hi_run    <= '0;
        end else begin
            en_seen <= tx_en;
            if (en_seen && !tx_en) begin
                since_end <= '0;
                end_ok    <= tp_sel && !sqe_test_n && (!full_dup || loopback);
            end else if (since_end != 8'hFF) begin
                since_end <= since_end + 8'd1;
            end
            hi_run <= col_o ? hi_run + 8'd1 : 8'd0;
        end
    end

    a_r1_reset_low: assert property (@(posedge clk) rst |=> !col_o);

    a_r2_start_time: assert property (@(posedge clk) disable iff (rst)
        $rose(col_o) |-> (since_end == 8'(DELAY)));

    a_r4_gated_start: assert property (@(posedge clk) disable iff (rst)
        $rose(col_o) |-> end_ok);

    a_r3_width_cap: assert property (@(posedge clk) disable iff (rst)
        col_o |-> (hi_run < 8'(WIDTH)));

    a_r3_full_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(col_o) && !$past(tx_en) && !$past(rst)) |-> (hi_run == 8'(WIDTH)));

    a_r7_tx_cancels: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> !col_o);
endmodule

bind sqe_test_gen sqe_test_gen_chk #(
    .DELAY (DELAY),
    .WIDTH (WIDTH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .tp_sel     (tp_sel),
    .sqe_test_n (sqe_test_n),
    .full_dup   (full_dup),
    .loopback   (loopback),
    .col_o      (col_o)
);

// File: tb/sqe_test_gen_tb.sv
module sqe_test_gen_tb_top;
    localparam int DELAY = 10;
    localparam int WIDTH = 10;
    localparam int WIN   = DELAY + WIDTH + 8;
    localparam int NVEC  = 9;

    // {tp_sel, sqe_test_n, full_dup, loopback, expect_pulse, frame_len[6:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {5'b1_0_0_0_1, 7'd20},   // R2 R3 R4 normal TP
        {5'b0_0_0_0_0, 7'd20},   // R4 attachment-unit port
        {5'b1_1_0_0_0, 7'd20},   // R4 test disabled
        {5'b1_0_1_0_0, 7'd20},   // R5 full duplex
        {5'b1_0_0_1_1, 7'd15},   // R6 loopback
        {5'b1_0_1_1_1, 7'd15},   // R6 loopback over full duplex
        {5'b0_0_0_1_0, 7'd15},   // R4 loopback on AUI
        {5'b1_0_0_0_1, 7'd1},    // R2 one-cycle frame
        {5'b0_1_1_1_0, 7'd30}    // R4 all blocked
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0;
    logic tp_sel = 1'b1;
    logic sqe_test_n = 1'b0;
    logic full_dup = 1'b0;
    logic loopback = 1'b0;
    logic col_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sqe_test_gen #(.DELAY(DELAY), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tp_sel(tp_sel),
        .sqe_test_n(sqe_test_n), .full_dup(full_dup),
        .loopback(loopback), .col_o(col_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_frame(int len);
        @(negedge clk) tx_en = 1'b1;
        for (int i = 1; i < len; i++) @(negedge clk);
        @(negedge clk) tx_en = 1'b0;
    endtask

    // Observe after frame end; t=1 is the negedge after the end-detect edge.
    task automatic measure(output int first, output int width);
        first = -1;
        width = 0;
        for (int t = 1; t <= WIN; t++) begin
            @(negedge clk);
            if (col_o) begin
                if (first < 0) first = t;
                width++;
            end
        end
    endtask

    initial begin : main
        int first, width;
        repeat (3) @(negedge clk);
        chk("R1 reset output", int'(col_o), 0);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            {tp_sel, sqe_test_n, full_dup, loopback} = VEC[v][11:8];
            send_frame(int'(VEC[v][6:0]));
            measure(first, width);
            if (VEC[v][7]) begin
                chk($sformatf("R2 start vec%0d", v), first, DELAY + 1);
                chk($sformatf("R3 width vec%0d", v), width, WIDTH);
            end else begin
                chk($sformatf("R4 R5 no pulse vec%0d", v), width, 0);
            end
        end

        // R8 / R7: restart during delay cancels, next frame pulses in full
        {tp_sel, sqe_test_n, full_dup, loopback} = 4'b1000;
        send_frame(12);
        repeat (4) @(negedge clk);
        tx_en = 1'b1;
        width = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (col_o) width++;
        end
        chk("R7 no pulse while restarted", width, 0);
        tx_en = 1'b0;
        measure(first, width);
        chk("R8 back-to-back start", first, DELAY + 1);
        chk("R8 back-to-back width", width, WIDTH);

        // R7: new frame in the middle of a pulse drops it at once
        send_frame(8);
        repeat (DELAY + 3) @(negedge clk);
        chk("R7 pulse running", int'(col_o), 1);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R7 cancel mid pulse", int'(col_o), 0);
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        measure(first, width);
        chk("R8 after cancel start", first, DELAY + 1);
        chk("R8 after cancel width", width, WIDTH);

        // R9: mode change after frame end keeps the decision
        send_frame(10);
        @(negedge clk) tp_sel = 1'b0;
        sqe_test_n = 1'b1;
        first = -1; width = 0;
        for (int t = 2; t <= WIN; t++) begin
            @(negedge clk);
            if (col_o) begin
                if (first < 0) first = t;
                width++;
            end
        end
        chk("R9 late mode change start", first, DELAY + 1);
        chk("R9 late mode change width", width, WIDTH);
        send_frame(10);
        @(negedge clk) tp_sel = 1'b1;
        sqe_test_n = 1'b0;
        width = 0;
        for (int t = 2; t <= WIN; t++) begin
            @(negedge clk);
            if (col_o) width++;
        end
        chk("R9 late enable no pulse", width, 0);

        // R1: reset mid pulse leaves nothing owed
        send_frame(10);
        repeat (DELAY + 2) @(negedge clk);
        chk("R1 pulse before reset", int'(col_o), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears pulse", int'(col_o), 0);
        rst = 1'b0;
        width = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (col_o) width++;
        end
        chk("R1 nothing after reset", width, 0);

        done = 1'b1;
    end

    initial begin : watchdog
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule